// File: doc/BRIEF.md
# Momentum Speed Ramp with Packet Watchdog

This block sits between a locomotive decoder's command parser and its motor drive. It takes the commanded speed step and produces a ramped speed value on a fine internal scale. The ramp therefore moves in small increments even when the command arrives in coarse 14-step or 28-step units. Separate acceleration and braking bytes set how fast the speed rises and falls. The time needed to cross the full speed range is the rate byte times 0.896 s, whatever the step mode. A rate of zero makes the output follow the command at once.

A packet watchdog runs alongside the ramp. An upstream parser pulses `pkt_ok_i` whenever it accepts a valid packet that concerns this decoder: a broadcast packet, or a packet to the primary address, the extended address when enabled, or the consist address when enabled. If no such pulse arrives within the timeout byte times ten seconds, the block raises `timeout_o`, treats the target as zero, and brakes at the braking rate. Function outputs are not handled here and are left alone. The next accepted packet ends the timeout and normal tracking resumes. Time is measured in periods of the `tick_i` pulse. The parameters `TICKS_PER_RATE` and `TO_TICKS` give 0.896 s and 10 s in ticks.

Top module: `momentum_ramp`

## Requirements
- R1: While `rst_n` is low, `speed_o` is 0 and `timeout_o` is 0.
- R2: The fine full scale is `FINE_FULL` (252). `mode_i` selects the step count: 0 gives 14 steps, 1 gives 28 steps, and 2 or 3 give 126 steps. The fine target is min(`target_i`, steps) × (252 / steps). `speed_o` never exceeds 252.
- R3: While the speed is below its target and `accel_i` is nonzero, starting from rest with a cleared accumulator, the speed after N ticks is min(target, floor(N×252 / (`accel_i`×896))). The speed changes by at most one fine unit per clock and does not change on a clock without a tick.
- R4: While the speed is above its target, `brake_i` paces the ramp by the same formula, and `accel_i` has no effect.
- R5: When the rate byte for the needed direction is 0, `speed_o` equals the fine target one clock later, with or without a tick.
- R6: In 14-step and 28-step modes the ramp passes through fine values that lie between multiples of the coarse step size.
- R7: With `tout_i` nonzero, `timeout_o` rises on the clock of the (`tout_i`×`TO_TICKS`)-th tick counted since the last `pkt_ok_i`. Before that tick it is 0.
- R8: With `tout_i` equal to 0, `timeout_o` stays 0 however many ticks pass.
- R9: A `pkt_ok_i` pulse clears `timeout_o` on the next clock and restarts the tick count from zero.
- R10: While `timeout_o` is high the target is zero and the speed falls at the braking rate. After the timeout clears, the speed tracks `target_i` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse per time quantum |
| pkt_ok_i | input | 1 | Pulse for each accepted packet that concerns this decoder |
| mode_i | input | 2 | Speed-step mode: 0 = 14, 1 = 28, 2 or 3 = 128 |
| target_i | input | TGT_W (8) | Commanded speed step |
| accel_i | input | RATE_W (8) | Acceleration rate byte |
| brake_i | input | RATE_W (8) | Braking rate byte |
| tout_i | input | TO_W (8) | Watchdog period in units of TO_TICKS ticks; 0 turns the watchdog off |
| speed_o | output | SPD_W (16) | Ramped speed on the fine scale, 0 to 252 |
| timeout_o | output | 1 | Watchdog has expired |

## Verification
The bound checker watches, on every clock, the properties that need no knowledge of the target. With both rates nonzero, the speed moves by at most one unit and stays still without a tick. While the timeout is high, the speed never rises. The flag clears after a packet, stays low when the watchdog is off, and rises only on a tick. The exact ramp rates, the scaling from steps to fine units in each mode, the zero-rate jump, the expiry tick count and recovery after a timeout all depend on elapsed time and the configuration. Only the bench scenarios, with closed-form expected values, can show these.

// File: rtl/ramp_pkg.sv
package ramp_pkg;

   typedef enum logic [1:0] {
      MODE_COARSE  = 2'd0,
      MODE_MEDIUM  = 2'd1,
      MODE_FINE    = 2'd2,
      MODE_FINE_B  = 2'd3
   } step_mode_e;

   localparam int unsigned NUM_MODES = 3;

   // number of commandable steps for each distinct mode index
   function automatic int unsigned mode_steps(input int unsigned idx);
      case (idx)
         0:       return 14;
         1:       return 28;
         default: return 126;
      endcase
   endfunction

endpackage

// File: rtl/ramp_target_map.sv
module ramp_target_map #(
   parameter int unsigned TGT_W     = 8,
   parameter int unsigned SPD_W     = 16,
   parameter int unsigned FINE_FULL = 252
) (
   input  logic [1:0]       mode_i,
   input  logic [TGT_W-1:0] target_i,
   input  logic             force_zero_i,
   output logic [SPD_W-1:0] fine_tgt_o
);
   import ramp_pkg::*;

   logic [SPD_W-1:0] fine_by_mode [NUM_MODES];

   for (genvar g = 0; g < NUM_MODES; g++) begin : g_mode
      localparam int unsigned STEPS = mode_steps(g);
      localparam int unsigned PER   = FINE_FULL / STEPS;

      if (FINE_FULL % STEPS != 0) begin : g_bad_div
         $error("FINE_FULL must divide evenly by every step count");
      end
      if (STEPS >= (1 << TGT_W)) begin : g_bad_tgt
         $error("TGT_W too narrow for step count");
      end

      always_comb begin
         if (target_i > TGT_W'(STEPS))
            fine_by_mode[g] = SPD_W'(STEPS * PER);
         else
            fine_by_mode[g] = SPD_W'(target_i) * SPD_W'(PER);
      end
   end

   always_comb begin
      if (force_zero_i) begin
         fine_tgt_o = '0;
      end else begin
         case (step_mode_e'(mode_i))
            MODE_COARSE: fine_tgt_o = fine_by_mode[0];
            MODE_MEDIUM: fine_tgt_o = fine_by_mode[1];
            default:     fine_tgt_o = fine_by_mode[2];
         endcase
      end
   end

endmodule

// File: rtl/ramp_pacer.sv
module ramp_pacer #(
   parameter int unsigned SPD_W          = 16,
   parameter int unsigned RATE_W         = 8,
   parameter int unsigned FINE_FULL      = 252,
   parameter int unsigned TICKS_PER_RATE = 896,
   parameter int unsigned ACC_W          = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [SPD_W-1:0]  speed_i,
   input  logic [SPD_W-1:0]  tgt_i,
   input  logic [RATE_W-1:0] accel_i,
   input  logic [RATE_W-1:0] brake_i,
   output logic              step_o,
   output logic              rise_o,
   output logic              snap_o
);
   logic              up, dn, moving;
   logic [RATE_W-1:0] rate;
   logic [ACC_W-1:0]  acc_q, acc_sum, thr;

   always_comb begin
      up      = tgt_i > speed_i;
      dn      = tgt_i < speed_i;
      moving  = up | dn;
      rate    = up ? accel_i : brake_i;
      thr     = ACC_W'(rate) * ACC_W'(TICKS_PER_RATE);
      acc_sum = acc_q + ACC_W'(FINE_FULL);
      snap_o  = moving && (rate == '0);
      step_o  = moving && tick_i && (rate != '0) && (acc_sum >= thr);
      rise_o  = up;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (!moving) begin
         acc_q <= '0;
      end else if (tick_i && (rate != '0)) begin
         acc_q <= step_o ? (acc_sum - thr) : acc_sum;
      end
   end

endmodule

// File: rtl/ramp_integrator.sv
module ramp_integrator #(
   parameter int unsigned SPD_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic             rise_i,
   input  logic             snap_i,
   input  logic [SPD_W-1:0] tgt_i,
   output logic [SPD_W-1:0] speed_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         speed_o <= '0;
      end else if (snap_i) begin
         speed_o <= tgt_i;
      end else if (step_i) begin
         speed_o <= rise_i ? speed_o + SPD_W'(1) : speed_o - SPD_W'(1);
      end
   end
endmodule

// File: rtl/ramp_watchdog.sv
module ramp_watchdog #(
   parameter int unsigned TO_W     = 8,
   parameter int unsigned TO_TICKS = 10000,
   parameter int unsigned CNT_W    = 22
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick_i,
   input  logic            pkt_ok_i,
   input  logic [TO_W-1:0] tout_i,
   output logic            timeout_o
);
   logic [CNT_W-1:0] cnt_q, cnt_nxt, limit;

   always_comb begin
      limit   = CNT_W'(tout_i) * CNT_W'(TO_TICKS);
      cnt_nxt = cnt_q + CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         timeout_o <= 1'b0;
      end else if (pkt_ok_i || (tout_i == '0)) begin
         cnt_q     <= '0;
         timeout_o <= 1'b0;
      end else if (tick_i && !timeout_o) begin
         if (cnt_nxt >= limit)
            timeout_o <= 1'b1;
         else
            cnt_q <= cnt_nxt;
      end
   end
endmodule

// File: rtl/momentum_ramp.sv
module momentum_ramp #(
   parameter int unsigned TGT_W          = 8,
   parameter int unsigned RATE_W         = 8,
   parameter int unsigned TO_W           = 8,
   parameter int unsigned SPD_W          = 16,
   parameter int unsigned FINE_FULL      = 252,
   parameter int unsigned TICKS_PER_RATE = 896,
   parameter int unsigned TO_TICKS       = 10000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              pkt_ok_i,
   input  logic [1:0]        mode_i,
   input  logic [TGT_W-1:0]  target_i,
   input  logic [RATE_W-1:0] accel_i,
   input  logic [RATE_W-1:0] brake_i,
   input  logic [TO_W-1:0]   tout_i,
   output logic [SPD_W-1:0]  speed_o,
   output logic              timeout_o
);
   localparam int unsigned ACC_W =
      $clog2((2 ** RATE_W) * TICKS_PER_RATE + FINE_FULL + 1);
   localparam int unsigned CNT_W =
      $clog2(((2 ** TO_W) - 1) * TO_TICKS + 2);

   if (FINE_FULL >= TICKS_PER_RATE) begin : g_bad_pace
      $error("TICKS_PER_RATE must exceed FINE_FULL (one unit per tick max)");
   end
   if (FINE_FULL >= (1 << SPD_W)) begin : g_bad_spd
      $error("SPD_W too narrow for FINE_FULL");
   end

   logic [SPD_W-1:0] fine_tgt;
   logic             step, rise, snap;

   ramp_target_map #(
      .TGT_W(TGT_W), .SPD_W(SPD_W), .FINE_FULL(FINE_FULL)
   ) u_map (
      .mode_i(mode_i), .target_i(target_i),
      .force_zero_i(timeout_o), .fine_tgt_o(fine_tgt)
   );

   ramp_pacer #(
      .SPD_W(SPD_W), .RATE_W(RATE_W), .FINE_FULL(FINE_FULL),
      .TICKS_PER_RATE(TICKS_PER_RATE), .ACC_W(ACC_W)
   ) u_pacer (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .speed_i(speed_o), .tgt_i(fine_tgt),
      .accel_i(accel_i), .brake_i(brake_i),
      .step_o(step), .rise_o(rise), .snap_o(snap)
   );

   ramp_integrator #(.SPD_W(SPD_W)) u_integ (
      .clk(clk), .rst_n(rst_n), .step_i(step), .rise_i(rise),
      .snap_i(snap), .tgt_i(fine_tgt), .speed_o(speed_o)
   );

   ramp_watchdog #(
      .TO_W(TO_W), .TO_TICKS(TO_TICKS), .CNT_W(CNT_W)
   ) u_wdog (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .pkt_ok_i(pkt_ok_i),
      .tout_i(tout_i), .timeout_o(timeout_o)
   );

endmodule

// File: rtl/momentum_ramp_chk.sv
module momentum_ramp_chk #(
   parameter int unsigned RATE_W    = 8,
   parameter int unsigned TO_W      = 8,
   parameter int unsigned SPD_W     = 16,
   parameter int unsigned FINE_FULL = 252
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_i,
   input logic              pkt_ok_i,
   input logic [RATE_W-1:0] accel_i,
   input logic [RATE_W-1:0] brake_i,
   input logic [TO_W-1:0]   tout_i,
   input logic [SPD_W-1:0]  speed_o,
   input logic              timeout_o
);
   logic live;
   always_ff @(posedge clk) begin
      if (!rst_n) live <= 1'b0;
      else        live <= 1'b1;
   end

   p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      speed_o <= SPD_W'(FINE_FULL));

   p_unit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (live && $past(accel_i) != '0 && $past(brake_i) != '0) |->
      (((speed_o >= $past(speed_o)) ? (speed_o - $past(speed_o))
                                    : ($past(speed_o) - speed_o)) <= SPD_W'(1)));

   p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (live && !$past(tick_i) && $past(accel_i) != '0 && $past(brake_i) != '0)
      |-> $stable(speed_o));

   p_rise_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (live && $rose(timeout_o)) |-> $past(tick_i));

   p_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (live && $past(tout_i) == '0) |-> !timeout_o);

   p_pkt_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (live && $past(pkt_ok_i)) |-> !timeout_o);

   p_no_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (live && $past(timeout_o)) |-> (speed_o <= $past(speed_o)));

endmodule

bind momentum_ramp momentum_ramp_chk #(
   .RATE_W(RATE_W), .TO_W(TO_W), .SPD_W(SPD_W), .FINE_FULL(FINE_FULL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .pkt_ok_i(pkt_ok_i),
   .accel_i(accel_i), .brake_i(brake_i), .tout_i(tout_i),
   .speed_o(speed_o), .timeout_o(timeout_o)
);

// File: tb/momentum_ramp_bench.sv
module momentum_ramp_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic        pkt_ok_i = 1'b0;
   logic [1:0]  mode_i = 2'd0;
   logic [7:0]  target_i = '0;
   logic [7:0]  accel_i = '0;
   logic [7:0]  brake_i = '0;
   logic [7:0]  tout_i = '0;
   logic [15:0] speed_o;
   logic        timeout_o;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   momentum_ramp #(.TO_TICKS(20)) u_momentum_ramp (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .pkt_ok_i(pkt_ok_i),
      .mode_i(mode_i), .target_i(target_i), .accel_i(accel_i),
      .brake_i(brake_i), .tout_i(tout_i),
      .speed_o(speed_o), .timeout_o(timeout_o)
   );

   typedef struct packed {
      logic [1:0]  mode;
      logic [7:0]  tgt;
      logic [7:0]  rate;
      logic [15:0] nticks;
      logic [15:0] expect_spd;
   } vec_t;

   // expected = min(fine target, floor(N*252/(rate*896))), or target when rate is 0
   localparam vec_t VECS [0:7] = '{
      '{2'd1, 8'd10,  8'd1, 16'd100,  16'd28},   // R3 28-step mid ramp
      '{2'd0, 8'd5,   8'd2, 16'd200,  16'd28},   // R6 14-step between coarse steps
      '{2'd2, 8'd126, 8'd0, 16'd1,    16'd252},  // R5 jump at rate 0
      '{2'd0, 8'd3,   8'd1, 16'd500,  16'd54},   // R3 capped at target
      '{2'd0, 8'd20,  8'd0, 16'd1,    16'd252},  // R2 step above max clamps
      '{2'd2, 8'd10,  8'd1, 16'd50,   16'd14},   // R3 128-step mode
      '{2'd3, 8'd60,  8'd0, 16'd1,    16'd120},  // R2 mode code 3 acts as 128
      '{2'd1, 8'd28,  8'd3, 16'd1000, 16'd93}    // R3 slower rate
   };

   task automatic check(input string req, input int got, input int exp);
      compared++;
      if (got != exp) begin
         mismatched++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic hold_reset();
      @(negedge clk);
      rst_n = 1'b0; tick_i = 1'b0; pkt_ok_i = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic release_reset();
      rst_n = 1'b1;
   endtask

   task automatic run_ticks(input int n);
      tick_i = 1'b1;
      repeat (n) @(negedge clk);
      tick_i = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_pkt();
      pkt_ok_i = 1'b1;
      @(negedge clk);
      pkt_ok_i = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog: got hung expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      // R1: reset state with an active command present
      hold_reset();
      mode_i = 2'd1; target_i = 8'd20; accel_i = 8'd0; brake_i = 8'd0; tout_i = 8'd1;
      idle(3);
      check("R1 speed", int'(speed_o), 0);
      check("R1 timeout", int'(timeout_o), 0);

      // table walk: each vector from rest
      foreach (VECS[i]) begin
         hold_reset();
         mode_i = VECS[i].mode; target_i = VECS[i].tgt;
         accel_i = VECS[i].rate; brake_i = VECS[i].rate; tout_i = 8'd0;
         release_reset();
         run_ticks(int'(VECS[i].nticks));
         check($sformatf("R2/R3/R5 vector %0d", i), int'(speed_o), int'(VECS[i].expect_spd));
         if (i == 1)
            check("R6 off coarse grid", int'(speed_o % 18 != 0), 1);
      end

      // R4: braking paced by brake byte, accel byte unused
      hold_reset();
      mode_i = 2'd1; target_i = 8'd20; accel_i = 8'd0; brake_i = 8'd2; tout_i = 8'd0;
      release_reset();
      idle(1);
      check("R5 jump up no tick", int'(speed_o), 180);
      target_i = 8'd0;
      run_ticks(100);
      check("R4 brake ramp", int'(speed_o), 166);

      // R7/R10/R9: watchdog expiry, forced stop, recovery
      hold_reset();
      mode_i = 2'd1; target_i = 8'd5; accel_i = 8'd0; brake_i = 8'd1; tout_i = 8'd3;
      release_reset();
      idle(1);
      pulse_pkt();
      run_ticks(59);
      check("R7 not yet expired", int'(timeout_o), 0);
      check("R7 speed before expiry", int'(speed_o), 45);
      run_ticks(1);
      check("R7 expired", int'(timeout_o), 1);
      run_ticks(32);
      check("R10 braking to zero", int'(speed_o), 36);
      check("R10 still timed out", int'(timeout_o), 1);
      pulse_pkt();
      check("R9 packet clears", int'(timeout_o), 0);
      idle(1);
      check("R10 tracking resumes", int'(speed_o), 45);

      // R9: packet restarts the count
      pulse_pkt();
      run_ticks(40);
      pulse_pkt();
      run_ticks(40);
      check("R9 count restarted", int'(timeout_o), 0);
      run_ticks(20);
      check("R9 expiry after restart", int'(timeout_o), 1);

      // R8: watchdog disabled
      tout_i = 8'd0;
      idle(1);
      check("R8 cleared when off", int'(timeout_o), 0);
      run_ticks(500);
      check("R8 stays off", int'(timeout_o), 0);
      check("R8 speed tracks target", int'(speed_o), 45);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule